// File: doc/BRIEF.md
# Superscalar Dispatch Slot Controller

This block stands between instruction decode and an out-of-order back end. Each cycle it decides whether the instruction offered at its input may leave for execution. It keeps a per-cycle budget of micro-op slots. An instruction too wide for one cycle may take a whole cycle, and the micro-ops it leaves over are carried into the following cycles, where they block new work. Before it accepts an instruction, the block consults three downstream resources: the physical register file, the retire (reorder) unit and the scheduler. It accepts only when all of them agree.

When an instruction is accepted, `in_ready` rises in the same cycle. One cycle later a single-cycle notice carries the micro-op count to the retire unit for slot reservation, together with a register-allocation request and the set of source operands to enter read-after-write tracking. An instruction marked both dependency-breaking and zero-latency is renamed away, so it requests no registers. A dependency-breaking instruction sends only its implicit sources for tracking. When the block refuses an instruction, it reports one encoded stall reason: the first gate that failed, in a fixed priority order.

Top module: `dispatch_slot_ctrl`

## Requirements
- R1: After reset the carry-over is zero and the full budget of DISPATCH_WIDTH slots is available, so an instruction of exactly DISPATCH_WIDTH micro-ops is accepted in the first cycle after reset. While reset is held, `disp_pulse` and `stall_valid` are 0.
- R2: A micro-op count of 0 on `in_uops` is treated as 1 everywhere: in the slot budget, in the retire-room test and in `disp_uops`.
- R3: An instruction of at most DISPATCH_WIDTH micro-ops whose gates all pass is accepted (`in_ready`=1) in the same cycle it is offered. At most one instruction is accepted per cycle.
- R4: An instruction with more than DISPATCH_WIDTH micro-ops may be accepted only when no carry-over is pending and all DISPATCH_WIDTH slots are free. On acceptance, the carry-over becomes its count minus DISPATCH_WIDTH.
- R5: At every clock edge the next cycle's budget is computed from the carry-over c: the available slots become 0 if c >= DISPATCH_WIDTH and DISPATCH_WIDTH - c otherwise, and the carry-over becomes c - DISPATCH_WIDTH, floored at 0. An instruction fits a non-oversized budget only if its count does not exceed the available slots.
- R6: While any carry-over is pending, no instruction is accepted and the stall code is slot stall.
- R7: A nonzero `rf_unavail` mask blocks acceptance, with stall code 2.
- R8: If `rob_free` is smaller than the effective micro-op count, the instruction is not accepted, and the stall code is 3.
- R9: If `sch_accept` is 0, the instruction is not accepted, and the stall code is {1'b1, `sch_reason`} (8 + reason with a 3-bit reason).
- R10: Gates are ranked slots (code 1), then register file (2), then retire unit (3), then scheduler. Only the highest-ranked failing gate is reported.
- R11: One cycle after an acceptance, `disp_pulse` is 1 for one cycle and `disp_uops` carries the effective count. In a cycle following no acceptance, `disp_pulse`, `disp_uops`, `rf_alloc_req` and `raw_track_mask` are 0.
- R12: `rf_alloc_req` accompanies `disp_pulse` unless the accepted instruction had both `in_dep_break` and `in_zero_lat` set. In that case it is 0.
- R13: `raw_track_mask` is `in_src_valid & in_src_implicit` for a dependency-breaking instruction and `in_src_valid` otherwise, captured at acceptance.
- R14: `stall_valid` is 1 exactly when `in_valid` is 1 and `in_ready` is 0. When it is 0, `stall_code` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | Offered instruction is accepted this cycle |
| in_uops | input | UOP_W | Micro-op count (0 counts as 1) |
| in_dep_break | input | 1 | Instruction breaks dependencies |
| in_zero_lat | input | 1 | Instruction has zero latency |
| in_src_valid | input | NUM_SRC | Source operands present |
| in_src_implicit | input | NUM_SRC | Source operands that are implicit |
| rf_unavail | input | NUM_DST | Register file: per-destination unavailability, all zero = grant |
| rob_free | input | ROB_CNT_W | Free entries in the retire unit |
| sch_accept | input | 1 | Scheduler grant |
| sch_reason | input | SCHED_RSN_W | Scheduler's refusal reason |
| stall_valid | output | 1 | Offered instruction is stalled |
| stall_code | output | SCHED_RSN_W+1 | Encoded stall reason |
| disp_pulse | output | 1 | Registered dispatch notice |
| disp_uops | output | UOP_W | Micro-ops to reserve in the retire unit |
| rf_alloc_req | output | 1 | Request physical register allocation |
| raw_track_mask | output | NUM_SRC | Sources sent to dependency tracking |

## Verification
The bench builds the block with DISPATCH_WIDTH=3, a 4-bit micro-op count, three sources, two destinations and a 5-bit retire free count. With a width of 3, the largest count of 15 leaves a carry of 12. This brings within reach several fully blocked cycles and an exact-multiple case, where a cycle with zero slots and zero carry follows, as well as partial budgets of one and two slots. The 5-bit free count reaches both sides of every retire-room comparison, and the 3-bit scheduler reason covers the whole upper half of the stall code.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [2:0] {
    GATE_NONE   = 3'd0,
    GATE_SLOT   = 3'd1,
    GATE_REGF   = 3'd2,
    GATE_RETIRE = 3'd3,
    GATE_SCHED  = 3'd4
  } gate_e;

  // micro-op count as used by every gate: zero counts as one
  function automatic int eff_count(input int raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  // slots granted at the start of a cycle, given the carry entering it
  function automatic int next_avail(input int carry, input int width);
    return (carry >= width) ? 0 : width - carry;
  endfunction

  // carry left after a cycle has absorbed its share
  function automatic int next_carry(input int carry, input int width);
    return (carry >= width) ? carry - width : 0;
  endfunction

  // does an instruction fit the current slot budget
  function automatic logic slot_fits(input int uops, input int avail,
                                     input int carry, input int width);
    if (carry != 0) return 1'b0;
    if (uops > width) return (avail == width);
    return (uops <= avail);
  endfunction

endpackage

// File: rtl/dsc_slot_budget.sv
module dsc_slot_budget #(
  parameter int W     = 4,
  parameter int UOP_W = 4,
  localparam int AW   = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [UOP_W-1:0] req_uops,
  input  logic             fire,
  output logic             slot_ok,
  output logic [AW-1:0]    avail_q,
  output logic [UOP_W-1:0] carry_q
);
  import dsc_pkg::*;

  int carry_after;

  always_comb begin
    carry_after = int'(carry_q);
    if (fire && (int'(req_uops) > W))
      carry_after = int'(req_uops) - W;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avail_q <= AW'(W);
      carry_q <= '0;
    end else begin
      avail_q <= AW'(next_avail(carry_after, W));
      carry_q <= UOP_W'(next_carry(carry_after, W));
    end
  end

  assign slot_ok = slot_fits(int'(req_uops), int'(avail_q), int'(carry_q), W);

endmodule

// File: rtl/dsc_gate_arbiter.sv
module dsc_gate_arbiter #(
  parameter int UOP_W       = 4,
  parameter int NUM_DST     = 2,
  parameter int ROB_CNT_W   = 6,
  parameter int SCHED_RSN_W = 3,
  localparam int STALL_W    = SCHED_RSN_W + 1
) (
  input  logic                   valid,
  input  logic                   slot_ok,
  input  logic [NUM_DST-1:0]     rf_unavail,
  input  logic [ROB_CNT_W-1:0]   rob_free,
  input  logic [UOP_W-1:0]       req_uops,
  input  logic                   sch_accept,
  input  logic [SCHED_RSN_W-1:0] sch_reason,
  output dsc_pkg::gate_e         first_fail,
  output logic                   accept,
  output logic                   stall,
  output logic [STALL_W-1:0]     code
);
  import dsc_pkg::*;

  logic rob_room;
  assign rob_room = (int'(rob_free) >= int'(req_uops));

  always_comb begin
    if (!slot_ok)               first_fail = GATE_SLOT;
    else if (rf_unavail != '0)  first_fail = GATE_REGF;
    else if (!rob_room)         first_fail = GATE_RETIRE;
    else if (!sch_accept)       first_fail = GATE_SCHED;
    else                        first_fail = GATE_NONE;
  end

  assign accept = valid && (first_fail == GATE_NONE);
  assign stall  = valid && (first_fail != GATE_NONE);

  always_comb begin
    code = '0;
    if (stall) begin
      case (first_fail)
        GATE_SLOT:   code = STALL_W'(1);
        GATE_REGF:   code = STALL_W'(2);
        GATE_RETIRE: code = STALL_W'(3);
        GATE_SCHED:  code = {1'b1, sch_reason};
        default:     code = '0;
      endcase
    end
  end

endmodule

// File: rtl/dsc_issue_pulse.sv
module dsc_issue_pulse #(
  parameter int UOP_W   = 4,
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [UOP_W-1:0]   fire_uops,
  input  logic               need_alloc,
  input  logic [NUM_SRC-1:0] track_mask,
  output logic               pulse_q,
  output logic [UOP_W-1:0]   uops_q,
  output logic               alloc_q,
  output logic [NUM_SRC-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (!rst_n || !fire) begin
      pulse_q <= 1'b0;
      uops_q  <= '0;
      alloc_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      pulse_q <= 1'b1;
      uops_q  <= fire_uops;
      alloc_q <= need_alloc;
      mask_q  <= track_mask;
    end
  end

endmodule

// File: rtl/dispatch_slot_ctrl.sv
module dispatch_slot_ctrl #(
  parameter int DISPATCH_WIDTH = 4,
  parameter int UOP_W          = 4,
  parameter int NUM_SRC        = 3,
  parameter int NUM_DST        = 2,
  parameter int ROB_CNT_W      = 6,
  parameter int SCHED_RSN_W    = 3,
  localparam int STALL_W       = SCHED_RSN_W + 1,
  localparam int AVAIL_W       = $clog2(DISPATCH_WIDTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [UOP_W-1:0]       in_uops,
  input  logic                   in_dep_break,
  input  logic                   in_zero_lat,
  input  logic [NUM_SRC-1:0]     in_src_valid,
  input  logic [NUM_SRC-1:0]     in_src_implicit,
  input  logic [NUM_DST-1:0]     rf_unavail,
  input  logic [ROB_CNT_W-1:0]   rob_free,
  input  logic                   sch_accept,
  input  logic [SCHED_RSN_W-1:0] sch_reason,
  output logic                   stall_valid,
  output logic [STALL_W-1:0]     stall_code,
  output logic                   disp_pulse,
  output logic [UOP_W-1:0]       disp_uops,
  output logic                   rf_alloc_req,
  output logic [NUM_SRC-1:0]     raw_track_mask
);
  import dsc_pkg::*;

  // named internal events, observed by the bound checker
  logic [UOP_W-1:0]   eff_uops;
  logic               fire;
  logic               slot_ok;
  logic               need_alloc;
  logic [AVAIL_W-1:0] avail_q;
  logic [UOP_W-1:0]   carry_q;
  logic [NUM_SRC-1:0] track_mask;
  gate_e              first_fail;

  assign eff_uops   = UOP_W'(eff_count(int'(in_uops)));
  assign need_alloc = !(in_dep_break && in_zero_lat);

  // per-source selection for read-after-write tracking
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign track_mask[s] = in_src_valid[s] && (in_src_implicit[s] || !in_dep_break);
  end

  dsc_slot_budget #(
    .W     (DISPATCH_WIDTH),
    .UOP_W (UOP_W)
  ) u_budget (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_uops (eff_uops),
    .fire     (fire),
    .slot_ok  (slot_ok),
    .avail_q  (avail_q),
    .carry_q  (carry_q)
  );

  dsc_gate_arbiter #(
    .UOP_W       (UOP_W),
    .NUM_DST     (NUM_DST),
    .ROB_CNT_W   (ROB_CNT_W),
    .SCHED_RSN_W (SCHED_RSN_W)
  ) u_arb (
    .valid      (in_valid),
    .slot_ok    (slot_ok),
    .rf_unavail (rf_unavail),
    .rob_free   (rob_free),
    .req_uops   (eff_uops),
    .sch_accept (sch_accept),
    .sch_reason (sch_reason),
    .first_fail (first_fail),
    .accept     (fire),
    .stall      (stall_valid),
    .code       (stall_code)
  );

  dsc_issue_pulse #(
    .UOP_W   (UOP_W),
    .NUM_SRC (NUM_SRC)
  ) u_pulse (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .fire_uops  (eff_uops),
    .need_alloc (need_alloc),
    .track_mask (track_mask),
    .pulse_q    (disp_pulse),
    .uops_q     (disp_uops),
    .alloc_q    (rf_alloc_req),
    .mask_q     (raw_track_mask)
  );

  assign in_ready = fire;

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int W         = 4,
  parameter int UOP_W     = 4,
  parameter int NUM_DST   = 2,
  parameter int ROB_CNT_W = 6,
  parameter int AVAIL_W   = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [UOP_W-1:0]     in_uops,
  input logic                 in_dep_break,
  input logic                 in_zero_lat,
  input logic [NUM_DST-1:0]   rf_unavail,
  input logic [ROB_CNT_W-1:0] rob_free,
  input logic                 stall_valid,
  input logic                 disp_pulse,
  input logic [UOP_W-1:0]     disp_uops,
  input logic                 rf_alloc_req,
  input logic [AVAIL_W-1:0]   avail_q,
  input logic [UOP_W-1:0]     carry_q,
  input logic                 fire,
  input logic [UOP_W-1:0]     eff_uops
);

  // R14
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> in_valid);

  // R14
  stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_valid |-> (in_valid && !in_ready));

  // R6
  carry_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_q != '0) |-> !in_ready);

  // R4
  over_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (int'(eff_uops) > W)) |-> (int'(avail_q) == W));

  // R4
  over_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (int'(eff_uops) > W)) |=> (int'(avail_q) != W));

  // R7
  regf_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (rf_unavail != '0)) |-> !in_ready);

  // R8
  retire_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (int'(rob_free) < int'(eff_uops))) |-> !in_ready);

  // R11
  pulse_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> disp_pulse);

  // R11
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !disp_pulse);

  // R11
  alloc_within_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_alloc_req |-> disp_pulse);

  // R12
  no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_dep_break && in_zero_lat) |=> !rf_alloc_req);

  // R2
  zero_as_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_uops == '0)) |=> (int'(disp_uops) == 1));

endmodule

bind dispatch_slot_ctrl dsc_checker #(
  .W         (DISPATCH_WIDTH),
  .UOP_W     (UOP_W),
  .NUM_DST   (NUM_DST),
  .ROB_CNT_W (ROB_CNT_W),
  .AVAIL_W   (AVAIL_W)
) u_dsc_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_uops      (in_uops),
  .in_dep_break (in_dep_break),
  .in_zero_lat  (in_zero_lat),
  .rf_unavail   (rf_unavail),
  .rob_free     (rob_free),
  .stall_valid  (stall_valid),
  .disp_pulse   (disp_pulse),
  .disp_uops    (disp_uops),
  .rf_alloc_req (rf_alloc_req),
  .avail_q      (avail_q),
  .carry_q      (carry_q),
  .fire         (fire),
  .eff_uops     (eff_uops)
);

// File: tb/dispatch_slot_ctrl_bench.sv
`timescale 1ns/1ps
module dispatch_slot_ctrl_bench;
  localparam int W     = 3;
  localparam int UW    = 4;
  localparam int NS    = 3;
  localparam int ND    = 2;
  localparam int RW    = 5;
  localparam int SRW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [UW-1:0] in_uops = '0;
  logic in_dep_break = 1'b0;
  logic in_zero_lat = 1'b0;
  logic [NS-1:0] in_src_valid = '0;
  logic [NS-1:0] in_src_implicit = '0;
  logic [ND-1:0] rf_unavail = '0;
  logic [RW-1:0] rob_free = '0;
  logic sch_accept = 1'b0;
  logic [SRW-1:0] sch_reason = '0;
  logic stall_valid;
  logic [SRW:0] stall_code;
  logic disp_pulse;
  logic [UW-1:0] disp_uops;
  logic rf_alloc_req;
  logic [NS-1:0] raw_track_mask;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model of the slot budget
  int m_avail, m_carry;
  int e_pulse, e_uops, e_alloc, e_mask;

  always #5 clk = ~clk;

  dispatch_slot_ctrl #(
    .DISPATCH_WIDTH(W), .UOP_W(UW), .NUM_SRC(NS), .NUM_DST(ND),
    .ROB_CNT_W(RW), .SCHED_RSN_W(SRW)
  ) u_dispatch_slot_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_uops(in_uops), .in_dep_break(in_dep_break), .in_zero_lat(in_zero_lat),
    .in_src_valid(in_src_valid), .in_src_implicit(in_src_implicit),
    .rf_unavail(rf_unavail), .rob_free(rob_free), .sch_accept(sch_accept),
    .sch_reason(sch_reason), .stall_valid(stall_valid), .stall_code(stall_code),
    .disp_pulse(disp_pulse), .disp_uops(disp_uops), .rf_alloc_req(rf_alloc_req),
    .raw_track_mask(raw_track_mask)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int eff(input int u);
    if (u == 0) return 1;
    return u;
  endfunction

  // expected stall code (0 = accept) and the requirement it stems from
  function automatic int exp_code(output string tag);
    int u;
    bit slot;
    u = eff(int'(in_uops));
    if (m_carry != 0) begin slot = 0; tag = "R6"; end
    else if (u > W) begin slot = (m_avail == W); tag = "R4"; end
    else begin slot = (u <= m_avail); tag = (m_avail == W) ? "R3" : "R5"; end
    if (!slot) return 1;
    if (rf_unavail != 0) begin tag = "R7"; return 2; end
    if (int'(rob_free) < u) begin tag = "R8"; return 3; end
    if (!sch_accept) begin tag = "R9"; return 8 + int'(sch_reason); end
    return 0;
  endfunction

  function automatic int n_gates_failing();
    int n;
    n = 0;
    if (rf_unavail != 0) n++;
    if (int'(rob_free) < eff(int'(in_uops))) n++;
    if (!sch_accept) n++;
    return n;
  endfunction

  // called right after a falling edge with inputs already driven
  task automatic run_cycle();
    string tag;
    int code, fire, c, u, mask;
    #1;
    chk("R11", "disp_pulse", int'(disp_pulse), e_pulse);
    chk("R11", "disp_uops", int'(disp_uops), e_uops);
    chk("R12", "rf_alloc_req", int'(rf_alloc_req), e_alloc);
    chk("R13", "raw_track_mask", int'(raw_track_mask), e_mask);
    code = exp_code(tag);
    if (!in_valid) begin
      code = 0;
      tag = "R14";
    end
    fire = in_valid && (code == 0);
    chk(tag, "in_ready", int'(in_ready), fire);
    chk("R14", "stall_valid", int'(stall_valid), (in_valid && code != 0) ? 1 : 0);
    if (code > 1 && n_gates_failing() > 1) tag = "R10";
    chk(tag, "stall_code", int'(stall_code), code);
    u = eff(int'(in_uops));
    mask = in_dep_break ? int'(in_src_valid & in_src_implicit) : int'(in_src_valid);
    @(posedge clk);
    c = (fire && u > W) ? u - W : m_carry;
    m_avail = (c >= W) ? 0 : W - c;
    m_carry = (c >= W) ? c - W : 0;
    e_pulse = fire;
    e_uops  = fire ? u : 0;
    e_alloc = (fire && !(in_dep_break && in_zero_lat)) ? 1 : 0;
    e_mask  = fire ? mask : 0;
    @(negedge clk);
  endtask

  task automatic drive(input bit v, input int u, input bit db, input bit zl,
                       input int sv, input int si, input int rfm, input int rob,
                       input bit acc, input int rsn);
    in_valid = v; in_uops = UW'(u); in_dep_break = db; in_zero_lat = zl;
    in_src_valid = NS'(sv); in_src_implicit = NS'(si); rf_unavail = ND'(rfm);
    rob_free = RW'(rob); sch_accept = acc; sch_reason = SRW'(rsn);
    run_cycle();
  endtask

  task automatic good(input int u);
    drive(1, u, 0, 0, 7, 0, 0, 31, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_avail = W; m_carry = 0;
    e_pulse = 0; e_uops = 0; e_alloc = 0; e_mask = 0;
    // R1: outputs quiet during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R1", "disp_pulse in reset", int'(disp_pulse), 0);
      chk("R1", "stall_valid in reset", int'(stall_valid), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R1: full budget right after reset
    good(W);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R2: zero counts as one for retire room and reservation
    drive(1, 0, 0, 0, 1, 0, 0, 0, 1, 0);
    drive(1, 0, 0, 0, 1, 0, 0, 1, 1, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R4 R5 R6: largest oversized instruction, carry drains to exact multiple
    good(15);
    for (int i = 0; i < 6; i++) good(1);
    // R5: partial budget after carry of 2
    good(5);
    good(2);
    good(2);
    // R4: oversized refused with partial budget
    good(4);
    good(4);
    good(4);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R10: priority order
    good(2);
    drive(1, 2, 0, 0, 7, 0, 3, 0, 0, 5);
    drive(1, 2, 0, 0, 7, 0, 3, 0, 0, 5);
    drive(1, 2, 0, 0, 7, 0, 0, 0, 0, 5);
    drive(1, 2, 0, 0, 7, 0, 0, 31, 0, 6);
    drive(1, 2, 0, 0, 7, 0, 0, 31, 0, 0);
    // R12 R13: renamed-away and dependency-breaking forms
    drive(1, 1, 1, 1, 7, 5, 0, 31, 1, 0);
    drive(1, 1, 1, 0, 6, 3, 0, 31, 1, 0);
    drive(1, 1, 0, 1, 5, 0, 0, 31, 1, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      drive(($urandom % 10) < 8, int'($urandom % 16),
            ($urandom % 3) == 0, ($urandom % 3) == 0,
            int'($urandom % 8), int'($urandom % 8),
            (($urandom % 8) == 0) ? int'($urandom % 4) : 0,
            (($urandom % 5) == 0) ? int'($urandom % 8) : int'($urandom % 32),
            ($urandom % 8) != 0, int'($urandom % 8));
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule